// File: doc/BRIEF.md
# Windowed Integer Register File

This block holds the integer registers of a processor core whose register name space is remapped through a rotating window. Every access names one of 32 logical registers with a 5-bit number. Eight of these names reach a set of shared global registers. A second bank of eight alternate globals can stand in for that set. The other 24 names reach the registers of the current window. A window owns eight incoming and eight local registers. Its eight outgoing registers are the incoming registers of the neighbouring window, so a caller's outgoing values appear as the callee's incoming values without any copy.

A call-style save moves the window pointer one window down, and a return-style restore moves it one window up. Both wrap around a circular set of windows whose count is a parameter from 3 to 32. A mask register marks windows that may not be entered. A save or restore that would enter a marked window leaves the pointer where it is and raises a one-cycle overflow or underflow flag. The surrounding pipeline handles those flags; spilling to memory is its job.

The file has two read ports and one write port. Reads are synchronous, with registered data outputs, and the storage is laid out so that an FPGA can map it to block RAM.

Top module: `winreg_file`

## Requirements
- R1: Logical register 0 reads as zero in both global banks, and a write to logical register 0 changes no register.
- R2: Logical numbers with bits [4:3] = 00 select a global register that does not change with the window pointer.
- R3: When `alt_glb` is 1, logical numbers 1 to 7 reach the alternate global bank; when it is 0 they reach the normal bank. Each bank keeps its own contents.
- R4: Bits [4:3] = 01 select the outgoing registers, 10 the locals and 11 the incoming registers. Outgoing register k of window w is the same storage as incoming register k of window w-1 (modulo the window count). Locals are private to each window.
- R5: A save moves the pointer to (w-1) mod N and a restore moves it to (w+1) mod N. The move takes effect at the clock edge that samples the strobe, so every access in the strobe cycle still uses the old window.
- R6: Read data appears on the clock edge after the index is presented. A read of the register being written in the same cycle returns the value from before the write.
- R7: A save whose target window has its mask bit set does not move the pointer, and `ovf_flag` is 1 for exactly the cycle after.
- R8: A restore whose target window has its mask bit set does not move the pointer, and `unf_flag` is 1 for exactly the cycle after.
- R9: A save and a restore in the same cycle cancel: the pointer stays and neither flag rises.
- R10: Reset (synchronous, active high) sets the pointer to window 0, clears the mask and both flags, and drives both read outputs to zero. Mask bit k is written from `wim_din` when `wim_we` is 1 and covers window k from the next cycle on.
- R11: After N saves in a row with no masked window, the pointer is back at its start window and that window's locals still hold their values.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| rd_a_idx | input | 5 | Logical index, read port A |
| rd_b_idx | input | 5 | Logical index, read port B |
| wr_en | input | 1 | Write enable |
| wr_idx | input | 5 | Logical index, write port |
| wr_data | input | DATA_W | Write data |
| alt_glb | input | 1 | Selects the alternate global bank for indices 0 to 7 |
| save_req | input | 1 | Call-style window save strobe |
| restore_req | input | 1 | Return-style window restore strobe |
| wim_we | input | 1 | Window mask write enable |
| wim_din | input | NWIN | New window mask, one bit per window |
| rd_a_data | output | DATA_W | Registered read data, port A |
| rd_b_data | output | DATA_W | Registered read data, port B |
| ovf_flag | output | 1 | One-cycle pulse: a save was refused |
| unf_flag | output | 1 | One-cycle pulse: a restore was refused |

## Verification
A window rotation and a register access can fall in the same cycle. This is also true of a write and a read of the same register. The bench provokes both: with directed steps that write an outgoing or local register while a save is strobed, and a write and two reads of one index in one step, and with random traffic where strobes, writes and reads overlap freely. The bench model resolves every read and write against the window and storage contents from before the edge. Only after that does it apply the write, the pointer move and the mask update. Any read that landed after the rotation or after the write then shows up as a data mismatch.

// File: rtl/wrf_pkg.sv
package wrf_pkg;

  // registers in one group (globals, outs, locals, ins)
  localparam int GRP_REGS  = 8;
  // physical registers owned by one window (ins + locals)
  localparam int WIN_SPAN  = 16;
  // physical base of the alternate global bank
  localparam int ALT_BASE  = 8;
  // physical base of the first window
  localparam int WIN_BASE  = 16;
  // offset of locals inside a window slice
  localparam int LOC_OFS   = 8;
  localparam int LIDX_W    = 5;

  typedef enum logic [1:0] {
    GRP_GLB = 2'b00,
    GRP_OUT = 2'b01,
    GRP_LOC = 2'b10,
    GRP_IN  = 2'b11
  } reg_grp_e;

  function automatic int phys_depth(input int nwin);
    return WIN_BASE + nwin * WIN_SPAN;
  endfunction

endpackage

// File: rtl/wrf_window_ctl.sv
module wrf_window_ctl #(
  parameter int NWIN  = 8,
  parameter int CWP_W = $clog2(NWIN)
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             save_req,
  input  logic             restore_req,
  input  logic             wim_we,
  input  logic [NWIN-1:0]  wim_din,
  output logic [CWP_W-1:0] cwp,
  output logic             ovf_flag,
  output logic             unf_flag
);

  localparam logic [CWP_W-1:0] LAST_WIN = CWP_W'(NWIN - 1);

  logic [NWIN-1:0]  wim_q;
  logic [CWP_W-1:0] nxt_dec;
  logic [CWP_W-1:0] nxt_inc;
  logic             do_save;
  logic             do_rest;
  logic             dec_blocked;
  logic             inc_blocked;

  always_comb begin
    nxt_dec     = (cwp == '0) ? LAST_WIN : cwp - 1'b1;
    nxt_inc     = (cwp == LAST_WIN) ? '0 : cwp + 1'b1;
    do_save     = save_req && !restore_req;
    do_rest     = restore_req && !save_req;
    dec_blocked = wim_q[nxt_dec];
    inc_blocked = wim_q[nxt_inc];
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      cwp      <= '0;
      wim_q    <= '0;
      ovf_flag <= 1'b0;
      unf_flag <= 1'b0;
    end else begin
      ovf_flag <= 1'b0;
      unf_flag <= 1'b0;
      if (do_save) begin
        if (dec_blocked) ovf_flag <= 1'b1;
        else             cwp      <= nxt_dec;
      end else if (do_rest) begin
        if (inc_blocked) unf_flag <= 1'b1;
        else             cwp      <= nxt_inc;
      end
      if (wim_we) wim_q <= wim_din;
    end
  end

endmodule

// File: rtl/wrf_index_map.sv
module wrf_index_map
  import wrf_pkg::*;
#(
  parameter int NWIN   = 8,
  parameter int CWP_W  = $clog2(NWIN),
  parameter int PHYS_W = $clog2(phys_depth(NWIN))
) (
  input  logic [LIDX_W-1:0] lidx,
  input  logic              alt,
  input  logic [CWP_W-1:0]  cwp,
  output logic [PHYS_W-1:0] paddr,
  output logic              is_zero
);

  reg_grp_e grp;
  int       cur_win;
  int       prv_win;
  int       slot;
  int       sel;

  always_comb begin
    grp     = reg_grp_e'(lidx[4:3]);
    slot    = int'(lidx[2:0]);
    cur_win = int'(cwp);
    prv_win = (cwp == '0) ? (NWIN - 1) : (cur_win - 1);
    is_zero = (lidx == '0);
    unique case (grp)
      GRP_GLB: sel = (alt ? ALT_BASE : 0) + slot;
      GRP_OUT: sel = WIN_BASE + prv_win * WIN_SPAN + slot;
      GRP_LOC: sel = WIN_BASE + cur_win * WIN_SPAN + LOC_OFS + slot;
      default: sel = WIN_BASE + cur_win * WIN_SPAN + slot;
    endcase
    paddr = PHYS_W'(sel);
  end

endmodule

// File: rtl/wrf_storage.sv
module wrf_storage #(
  parameter int DATA_W = 64,
  parameter int DEPTH  = 144,
  parameter int AW     = $clog2(DEPTH),
  parameter int NRD    = 2
) (
  input  logic                       clk,
  input  logic                       rst,
  input  logic                       we,
  input  logic [AW-1:0]              waddr,
  input  logic [DATA_W-1:0]          wdata,
  input  logic [NRD-1:0][AW-1:0]     raddr,
  input  logic [NRD-1:0]             rzero,
  output logic [NRD-1:0][DATA_W-1:0] rdata
);

  logic [DATA_W-1:0] mem [DEPTH];

  // write port: no reset on the array so it can map to block RAM
  always_ff @(posedge clk) begin
    if (we) mem[waddr] <= wdata;
  end

  // read ports: read-first, registered output with synchronous reset
  always_ff @(posedge clk) begin
    for (int r = 0; r < NRD; r++) begin
      if (rst)           rdata[r] <= '0;
      else if (rzero[r]) rdata[r] <= '0;
      else               rdata[r] <= mem[raddr[r]];
    end
  end

endmodule

// File: rtl/winreg_file.sv
module winreg_file
  import wrf_pkg::*;
#(
  parameter int DATA_W = 64,
  parameter int NWIN   = 8
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [4:0]        rd_a_idx,
  input  logic [4:0]        rd_b_idx,
  input  logic              wr_en,
  input  logic [4:0]        wr_idx,
  input  logic [DATA_W-1:0] wr_data,
  input  logic              alt_glb,
  input  logic              save_req,
  input  logic              restore_req,
  input  logic              wim_we,
  input  logic [NWIN-1:0]   wim_din,
  output logic [DATA_W-1:0] rd_a_data,
  output logic [DATA_W-1:0] rd_b_data,
  output logic              ovf_flag,
  output logic              unf_flag
);

  localparam int DEPTH  = phys_depth(NWIN);
  localparam int PHYS_W = $clog2(DEPTH);
  localparam int CWP_W  = $clog2(NWIN);
  localparam int NRD    = 2;
  localparam int NMAP   = NRD + 1;  // read ports then the write port
  localparam int WR_MAP = NRD;

  logic [CWP_W-1:0]                cwp;
  logic [NMAP-1:0][LIDX_W-1:0]     map_idx;
  logic [NMAP-1:0][PHYS_W-1:0]     map_addr;
  logic [NMAP-1:0]                 map_zero;
  logic [NRD-1:0][DATA_W-1:0]      rd_q;
  logic                            wr_commit;

  assign map_idx[0]      = rd_a_idx;
  assign map_idx[1]      = rd_b_idx;
  assign map_idx[WR_MAP] = wr_idx;

  wrf_window_ctl #(
    .NWIN  (NWIN),
    .CWP_W (CWP_W)
  ) u_ctl (
    .clk         (clk),
    .rst         (rst),
    .save_req    (save_req),
    .restore_req (restore_req),
    .wim_we      (wim_we),
    .wim_din     (wim_din),
    .cwp         (cwp),
    .ovf_flag    (ovf_flag),
    .unf_flag    (unf_flag)
  );

  for (genvar p = 0; p < NMAP; p++) begin : g_map
    wrf_index_map #(
      .NWIN   (NWIN),
      .CWP_W  (CWP_W),
      .PHYS_W (PHYS_W)
    ) u_map (
      .lidx    (map_idx[p]),
      .alt     (alt_glb),
      .cwp     (cwp),
      .paddr   (map_addr[p]),
      .is_zero (map_zero[p])
    );
  end

  assign wr_commit = wr_en && !map_zero[WR_MAP];

  wrf_storage #(
    .DATA_W (DATA_W),
    .DEPTH  (DEPTH),
    .AW     (PHYS_W),
    .NRD    (NRD)
  ) u_mem (
    .clk   (clk),
    .rst   (rst),
    .we    (wr_commit),
    .waddr (map_addr[WR_MAP]),
    .wdata (wr_data),
    .raddr (map_addr[NRD-1:0]),
    .rzero (map_zero[NRD-1:0]),
    .rdata (rd_q)
  );

  assign rd_a_data = rd_q[0];
  assign rd_b_data = rd_q[1];

endmodule

// File: rtl/winreg_file_chk.sv
module winreg_file_chk #(
  parameter int DATA_W = 64,
  parameter int NWIN   = 8,
  parameter int CWP_W  = $clog2(NWIN)
) (
  input logic              clk,
  input logic              rst,
  input logic              save_req,
  input logic              restore_req,
  input logic [CWP_W-1:0]  cwp,
  input logic              ovf_flag,
  input logic              unf_flag,
  input logic [4:0]        rd_a_idx,
  input logic [4:0]        rd_b_idx,
  input logic [DATA_W-1:0] rd_a_data,
  input logic [DATA_W-1:0] rd_b_data
);

  function automatic logic [CWP_W-1:0] wdec(input logic [CWP_W-1:0] w);
    return (w == '0) ? CWP_W'(NWIN - 1) : w - 1'b1;
  endfunction

  function automatic logic [CWP_W-1:0] winc(input logic [CWP_W-1:0] w);
    return (w == CWP_W'(NWIN - 1)) ? '0 : w + 1'b1;
  endfunction

  // R1: index 0 yields zero on both read ports
  p_zero_read_r1: assert property (@(posedge clk) disable iff (rst)
    ($past(rd_a_idx) == 5'd0) |-> (rd_a_data == '0));
  p_zero_readb_r1: assert property (@(posedge clk) disable iff (rst)
    ($past(rd_b_idx) == 5'd0) |-> (rd_b_data == '0));

  // R5: the pointer only moves by one window, wrapping
  p_step_r5: assert property (@(posedge clk) disable iff (rst)
    (!$past(rst) && cwp != $past(cwp)) |->
      (cwp == wdec($past(cwp)) || cwp == winc($past(cwp))));

  // R7: overflow only after a lone save, and the pointer held
  p_ovf_cause_r7: assert property (@(posedge clk) disable iff (rst)
    ovf_flag |-> ($past(save_req) && !$past(restore_req) && cwp == $past(cwp)));

  // R8: underflow only after a lone restore, and the pointer held
  p_unf_cause_r8: assert property (@(posedge clk) disable iff (rst)
    unf_flag |-> ($past(restore_req) && !$past(save_req) && cwp == $past(cwp)));

  // R9: both strobes cancel
  p_both_hold_r9: assert property (@(posedge clk) disable iff (rst)
    (!$past(rst) && $past(save_req) && $past(restore_req)) |->
      (cwp == $past(cwp) && !ovf_flag && !unf_flag));

  // R7/R8: never both flags at once
  p_flag_excl_r7: assert property (@(posedge clk) disable iff (rst)
    !(ovf_flag && unf_flag));

endmodule

bind winreg_file winreg_file_chk #(
  .DATA_W (DATA_W),
  .NWIN   (NWIN)
) u_chk (
  .clk         (clk),
  .rst         (rst),
  .save_req    (save_req),
  .restore_req (restore_req),
  .cwp         (cwp),
  .ovf_flag    (ovf_flag),
  .unf_flag    (unf_flag),
  .rd_a_idx    (rd_a_idx),
  .rd_b_idx    (rd_b_idx),
  .rd_a_data   (rd_a_data),
  .rd_b_data   (rd_b_data)
);

// File: tb/winreg_file_test.sv
`timescale 1ns/1ps
module winreg_file_test;

  localparam int DW = 64;
  localparam int NW = 8;

  logic          clk = 1'b0;
  logic          rst = 1'b1;
  logic [4:0]    rd_a_idx = '0, rd_b_idx = '0, wr_idx = '0;
  logic          wr_en = 1'b0, alt_glb = 1'b0, save_req = 1'b0, restore_req = 1'b0;
  logic          wim_we = 1'b0;
  logic [NW-1:0] wim_din = '0;
  logic [DW-1:0] wr_data = '0;
  logic [DW-1:0] rd_a_data, rd_b_data;
  logic          ovf_flag, unf_flag;

  int n_chk = 0;
  int n_fail = 0;
  bit done = 1'b0;

  always #4 clk = ~clk;  // 125 MHz

  winreg_file #(.DATA_W(DW), .NWIN(NW)) uut (
    .clk(clk), .rst(rst), .rd_a_idx(rd_a_idx), .rd_b_idx(rd_b_idx),
    .wr_en(wr_en), .wr_idx(wr_idx), .wr_data(wr_data), .alt_glb(alt_glb),
    .save_req(save_req), .restore_req(restore_req), .wim_we(wim_we),
    .wim_din(wim_din), .rd_a_data(rd_a_data), .rd_b_data(rd_b_data),
    .ovf_flag(ovf_flag), .unf_flag(unf_flag)
  );

  // ---------------- reference model, built from the requirements
  logic [DW-1:0] m_g  [8];
  logic [DW-1:0] m_ag [8];
  logic [DW-1:0] m_in [NW][8];
  logic [DW-1:0] m_lo [NW][8];
  bit            v_g  [8];
  bit            v_ag [8];
  bit            v_in [NW][8];
  bit            v_lo [NW][8];
  int            m_cwp = 0;
  logic [NW-1:0] m_wim = '0;

  function automatic int below(input int w);
    return (w + NW - 1) % NW;
  endfunction

  function automatic int above(input int w);
    return (w + 1) % NW;
  endfunction

  task automatic mread(input logic [4:0] i, input bit a,
                       output logic [DW-1:0] v, output bit ok);
    int r = int'(i[2:0]);
    if (i == 5'd0) begin v = '0; ok = 1'b1; end
    else case (i[4:3])
      2'b00: if (a) begin v = m_ag[r]; ok = v_ag[r]; end
             else   begin v = m_g[r];  ok = v_g[r];  end
      2'b01: begin v = m_in[below(m_cwp)][r]; ok = v_in[below(m_cwp)][r]; end
      2'b10: begin v = m_lo[m_cwp][r]; ok = v_lo[m_cwp][r]; end
      default: begin v = m_in[m_cwp][r]; ok = v_in[m_cwp][r]; end
    endcase
  endtask

  task automatic mwrite(input logic [4:0] i, input bit a, input logic [DW-1:0] d);
    int r = int'(i[2:0]);
    if (i == 5'd0) return;
    case (i[4:3])
      2'b00: if (a) begin m_ag[r] = d; v_ag[r] = 1'b1; end
             else   begin m_g[r]  = d; v_g[r]  = 1'b1; end
      2'b01: begin m_in[below(m_cwp)][r] = d; v_in[below(m_cwp)][r] = 1'b1; end
      2'b10: begin m_lo[m_cwp][r] = d; v_lo[m_cwp][r] = 1'b1; end
      default: begin m_in[m_cwp][r] = d; v_in[m_cwp][r] = 1'b1; end
    endcase
  endtask

  task automatic check(input bit ok, input string tag,
                       input logic [DW-1:0] act, input logic [DW-1:0] exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic idle();
    wr_en = 1'b0; save_req = 1'b0; restore_req = 1'b0; wim_we = 1'b0;
    alt_glb = 1'b0; rd_a_idx = '0; rd_b_idx = '0; wr_idx = '0;
  endtask

  // one clock: inputs are already driven; compare after the edge
  task automatic step(input string tag);
    logic [DW-1:0] ea, eb;
    bit oka, okb, eo, eu;
    int nd;
    mread(rd_a_idx, alt_glb, ea, oka);
    mread(rd_b_idx, alt_glb, eb, okb);
    eo = 1'b0; eu = 1'b0;
    if (wr_en) mwrite(wr_idx, alt_glb, wr_data);
    if (save_req && !restore_req) begin
      nd = below(m_cwp);
      if (m_wim[nd]) eo = 1'b1; else m_cwp = nd;
    end else if (restore_req && !save_req) begin
      nd = above(m_cwp);
      if (m_wim[nd]) eu = 1'b1; else m_cwp = nd;
    end
    if (wim_we) m_wim = wim_din;
    @(posedge clk);
    #1;
    if (oka) check(rd_a_data === ea, tag, rd_a_data, ea);
    if (okb) check(rd_b_data === eb, tag, rd_b_data, eb);
    check(ovf_flag === eo, "R7 ovf_flag", DW'(ovf_flag), DW'(eo));
    check(unf_flag === eu, "R8 unf_flag", DW'(unf_flag), DW'(eu));
    idle();
  endtask

  task automatic wr(input logic [4:0] i, input bit a, input logic [DW-1:0] d, input string tag);
    wr_en = 1'b1; wr_idx = i; wr_data = d; alt_glb = a; step(tag);
  endtask

  task automatic rd(input logic [4:0] i, input bit a, input string tag);
    rd_a_idx = i; rd_b_idx = i; alt_glb = a; step(tag);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      n_fail++;
      $display("FAIL watchdog expired (R10 run did not end)");
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
    end
  end

  initial begin
    int seed_dummy;
    for (int r = 0; r < 8; r++) begin
      v_g[r] = 1'b0; v_ag[r] = 1'b0; m_g[r] = '0; m_ag[r] = '0;
    end
    for (int w = 0; w < NW; w++)
      for (int r = 0; r < 8; r++) begin
        v_in[w][r] = 1'b0; v_lo[w][r] = 1'b0; m_in[w][r] = '0; m_lo[w][r] = '0;
      end
    seed_dummy = $urandom(32'd20240611);

    idle();
    repeat (3) @(posedge clk);
    #1 rst = 1'b0;
    // R10: reset state at the ports
    check(rd_a_data === '0, "R10 rd_a after reset", rd_a_data, '0);
    check(rd_b_data === '0, "R10 rd_b after reset", rd_b_data, '0);
    check(ovf_flag === 1'b0 && unf_flag === 1'b0, "R10 flags after reset",
          DW'({ovf_flag, unf_flag}), '0);

    // R1: zero register in both banks
    wr(5'd0, 1'b0, 64'hDEAD_BEEF_0000_0001, "R1 write r0");
    wr(5'd0, 1'b1, 64'hDEAD_BEEF_0000_0002, "R1 write alt r0");
    rd(5'd0, 1'b0, "R1 read r0");
    rd(5'd0, 1'b1, "R1 read alt r0");

    // R3: banks separate
    wr(5'd1, 1'b0, 64'h1111_0000_0000_0001, "R3 write normal g1");
    wr(5'd1, 1'b1, 64'hAAAA_0000_0000_0001, "R3 write alt g1");
    rd(5'd1, 1'b0, "R3 normal g1");
    rd(5'd1, 1'b1, "R3 alt g1");

    // R2: globals unaffected by rotation
    save_req = 1'b1; step("R2 save");
    rd(5'd1, 1'b0, "R2 g1 after save");

    // R4: outgoing of caller equals incoming of callee
    wr(5'd9, 1'b0, 64'h0C0C_0C0C_0000_0009, "R4 write out1");
    save_req = 1'b1; step("R4 save");
    rd(5'd25, 1'b0, "R4 in1 after save");
    wr(5'd16, 1'b0, 64'h1010_0000_0000_0001, "R4 local in window");
    save_req = 1'b1; step("R4 save2");
    wr(5'd16, 1'b0, 64'h2020_0000_0000_0002, "R4 local next window");
    restore_req = 1'b1; step("R4 restore");
    rd(5'd16, 1'b0, "R4 local kept");

    // R6: read-first in the write cycle, new value next
    wr(5'd17, 1'b0, 64'hA1A1_0000_0000_0017, "R6 first write");
    rd_a_idx = 5'd17; rd_b_idx = 5'd17;
    wr(5'd17, 1'b0, 64'hB2B2_0000_0000_0017, "R6 same-cycle read old");
    rd(5'd17, 1'b0, "R6 read new");

    // R5: write during save lands in the old window
    rd_a_idx = 5'd20;
    save_req = 1'b1;
    wr(5'd20, 1'b0, 64'hE0E0_0000_0000_0020, "R5 write with save");
    rd(5'd20, 1'b0, "R5 new window read");
    restore_req = 1'b1; step("R5 restore");
    rd(5'd20, 1'b0, "R5 old window kept write");

    // R7: refused save
    wim_we = 1'b1; wim_din = NW'(1) << below(m_cwp); step("R10 wim write");
    save_req = 1'b1; step("R7 blocked save");
    rd(5'd20, 1'b0, "R7 window unchanged");

    // R8: refused restore
    wim_we = 1'b1; wim_din = NW'(1) << above(m_cwp); step("R10 wim write 2");
    restore_req = 1'b1; step("R8 blocked restore");
    rd(5'd20, 1'b0, "R8 window unchanged");
    wim_we = 1'b1; wim_din = '0; step("R10 wim clear");

    // R9: both strobes cancel
    save_req = 1'b1; restore_req = 1'b1; step("R9 both strobes");
    rd(5'd20, 1'b0, "R9 window unchanged");

    // R11: full wrap
    wr(5'd18, 1'b0, 64'h5A5A_0000_0000_0018, "R11 write local");
    for (int k = 0; k < NW; k++) begin save_req = 1'b1; step("R11 save"); end
    rd(5'd18, 1'b0, "R11 local after wrap");

    // random mixed traffic
    for (int n = 0; n < 3000; n++) begin
      rd_a_idx    = 5'($urandom % 32);
      rd_b_idx    = ($urandom % 4 == 0) ? wr_idx : 5'($urandom % 32);
      wr_en       = ($urandom % 2) == 0;
      wr_idx      = 5'($urandom % 32);
      wr_data     = {$urandom, $urandom};
      alt_glb     = ($urandom % 4) == 0;
      save_req    = ($urandom % 4) == 0;
      restore_req = ($urandom % 4) == 1;
      if ($urandom % 16 == 15) begin save_req = 1'b1; restore_req = 1'b1; end
      wim_we      = ($urandom % 50) == 0;
      wim_din     = NW'($urandom & $urandom & $urandom);
      step("R6 random read");
    end

    done = 1'b1;
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

endmodule